// File: doc/BRIEF.md
# Persistent Path Byte Monitor

This block watches one path user overhead byte on each of several tributaries. Once per frame, the framer presents the byte for a tributary together with a strobe. The monitor accepts a new value only after that exact 8-bit pattern has arrived on a run of consecutive frames. The length of the run is set by a shared 4-bit threshold. Each tributary holds two values: the value it last accepted, and the value accepted before that as history.

When a tributary's accepted value changes, a sticky change flag for that tributary is set. A mask bit per tributary decides whether the flag reaches the single interrupt output. The flag stays set until a per-tributary clear pulse removes it. An out-of-frame indication from the framer discards the run in progress. The tributaries are fully independent of one another. They share only the threshold input.

Top module: `path_byte_monitor`

## Requirements
- R1: After reset every accepted value, every history value and every change flag is zero, and the interrupt is low.
- R2: A tributary's accepted value changes at the clock edge that samples the strobe of the frame which completes the run of identical bytes set by the threshold. It does not change at any earlier frame, and it does not change in a cycle with no strobe.
- R3: A byte that differs from the current candidate makes it the new candidate and restarts the run at one frame.
- R4: A threshold of 0 behaves as a threshold of 1.
- R5: When a new value is accepted, the value it replaces moves into that tributary's history in the same cycle.
- R6: Completing a run of a byte equal to the current accepted value changes neither the history nor the change flag.
- R7: Every change of an accepted value sets that tributary's change flag. The flag stays set until a clear pulse on that tributary. If a set and a clear arrive in the same cycle, the set wins.
- R8: The interrupt is high exactly when at least one change flag is set whose mask bit is 0. A mask bit of 1 blocks that flag.
- R9: While the out-of-frame input of a tributary is high, its run count returns to zero, and any strobe in that cycle is not counted.
- R10: A strobe, an out-of-frame indication or a clear on one tributary has no effect on the accepted value, history or flag of another tributary.
- R11: Idle cycles between two strobes do not break a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | NUM_TRIB | Per-tributary strobe: the frame's byte is present |
| frame_byte | input | NUM_TRIB*BYTE_W | Per-tributary received byte; tributary i in bits [i*BYTE_W +: BYTE_W] |
| oof | input | NUM_TRIB | Per-tributary out-of-frame indication |
| persist_thr | input | THR_W | Consecutive identical frames needed before acceptance; 0 acts as 1 |
| irq_mask | input | NUM_TRIB | 1 blocks that tributary's flag from the interrupt |
| flag_clr | input | NUM_TRIB | Per-tributary clear pulse for the change flag |
| accepted | output | NUM_TRIB*BYTE_W | Currently accepted value per tributary |
| history | output | NUM_TRIB*BYTE_W | Previously accepted value per tributary |
| change_flag | output | NUM_TRIB | Sticky per-tributary change flags |
| irq | output | 1 | OR of the unmasked change flags |

## Verification
The bench builds the block with its default parameters: three tributaries, 8-bit bytes and a 4-bit threshold. Three lanes are enough to show that the lanes are isolated from each other and that the mask combines them into one interrupt. Because the threshold is a run-time input and not a parameter, the bench can try thresholds of 0, 1, 2 and 3 in one elaboration. With these small values every acceptance, restart and out-of-frame discard takes only a few frames, so each run boundary is checked frame by frame.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
    // Classification of what a lane does with the current cycle.
    typedef enum logic [1:0] {
        EV_IDLE    = 2'd0,
        EV_DISCARD = 2'd1,
        EV_MATCH   = 2'd2,
        EV_RESTART = 2'd3
    } lane_ev_e;
endpackage

// File: rtl/pbm_lane.sv
module pbm_lane
    import pbm_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned THR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              oof_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [THR_W-1:0]  thr_i,
    output logic [BYTE_W-1:0] acc_o,
    output logic [BYTE_W-1:0] hist_o,
    output logic              upd_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] cand;
        logic [THR_W-1:0]  cnt;
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] hist;
    } lane_s;

    lane_s       lane_d, lane_q;
    lane_ev_e    ev;
    logic [THR_W-1:0] thr_eff;
    logic        upd_d;

    always_comb begin
        lane_d  = lane_q;
        upd_d   = 1'b0;
        thr_eff = (thr_i == '0) ? THR_W'(1) : thr_i;
        if (oof_i) begin
            ev = EV_DISCARD;
        end else if (!valid_i) begin
            ev = EV_IDLE;
        end else if ((lane_q.cnt != '0) && (byte_i == lane_q.cand)) begin
            ev = EV_MATCH;
        end else begin
            ev = EV_RESTART;
        end

        case (ev)
            EV_DISCARD: lane_d.cnt = '0;
            EV_MATCH: begin
                if (lane_q.cnt < thr_eff) begin
                    lane_d.cnt = lane_q.cnt + THR_W'(1);
                end
            end
            EV_RESTART: begin
                lane_d.cand = byte_i;
                lane_d.cnt  = THR_W'(1);
            end
            default: ;
        endcase

        if (((ev == EV_MATCH) || (ev == EV_RESTART)) &&
            (lane_d.cnt >= thr_eff) && (byte_i != lane_q.acc)) begin
            lane_d.hist = lane_q.acc;
            lane_d.acc  = byte_i;
            upd_d       = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign acc_o  = lane_q.acc;
    assign hist_o = lane_q.hist;
    assign upd_o  = upd_d;
endmodule

// File: rtl/pbm_flags.sv
module pbm_flags #(
    parameter int unsigned NUM_TRIB = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIB-1:0] set_i,
    input  logic [NUM_TRIB-1:0] clr_i,
    input  logic [NUM_TRIB-1:0] mask_i,
    output logic [NUM_TRIB-1:0] flag_o,
    output logic                irq_o
);
    typedef struct packed {
        logic [NUM_TRIB-1:0] flag;
    } flag_s;

    flag_s flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        for (int i = 0; i < NUM_TRIB; i++) begin
            if (set_i[i]) begin
                flag_d.flag[i] = 1'b1;
            end else if (clr_i[i]) begin
                flag_d.flag[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q.flag;
    assign irq_o  = |(flag_q.flag & ~mask_i);
endmodule

// File: rtl/path_byte_monitor.sv
module path_byte_monitor #(
    parameter int unsigned NUM_TRIB = 3,
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned THR_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_TRIB-1:0]        frame_valid,
    input  logic [NUM_TRIB*BYTE_W-1:0] frame_byte,
    input  logic [NUM_TRIB-1:0]        oof,
    input  logic [THR_W-1:0]           persist_thr,
    input  logic [NUM_TRIB-1:0]        irq_mask,
    input  logic [NUM_TRIB-1:0]        flag_clr,
    output logic [NUM_TRIB*BYTE_W-1:0] accepted,
    output logic [NUM_TRIB*BYTE_W-1:0] history,
    output logic [NUM_TRIB-1:0]        change_flag,
    output logic                       irq
);
    logic [NUM_TRIB-1:0] upd;

    for (genvar g = 0; g < NUM_TRIB; g++) begin : g_lane
        pbm_lane #(
            .BYTE_W (BYTE_W),
            .THR_W  (THR_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (frame_valid[g]),
            .oof_i   (oof[g]),
            .byte_i  (frame_byte[g*BYTE_W +: BYTE_W]),
            .thr_i   (persist_thr),
            .acc_o   (accepted[g*BYTE_W +: BYTE_W]),
            .hist_o  (history[g*BYTE_W +: BYTE_W]),
            .upd_o   (upd[g])
        );
    end

    pbm_flags #(
        .NUM_TRIB (NUM_TRIB)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (upd),
        .clr_i  (flag_clr),
        .mask_i (irq_mask),
        .flag_o (change_flag),
        .irq_o  (irq)
    );
endmodule

// File: rtl/pbm_checker.sv
module pbm_checker #(
    parameter int unsigned NUM_TRIB = 3,
    parameter int unsigned BYTE_W   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_TRIB-1:0]        frame_valid,
    input logic [NUM_TRIB-1:0]        oof,
    input logic [NUM_TRIB-1:0]        irq_mask,
    input logic [NUM_TRIB-1:0]        flag_clr,
    input logic [NUM_TRIB*BYTE_W-1:0] accepted,
    input logic [NUM_TRIB*BYTE_W-1:0] history,
    input logic [NUM_TRIB-1:0]        change_flag,
    input logic                       irq
);
    for (genvar g = 0; g < NUM_TRIB; g++) begin : g_chk
        // R2: no strobe, no change of the accepted value
        p_acc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_valid[g] |=> $stable(accepted[g*BYTE_W +: BYTE_W]));
        // R9: a strobe during out-of-frame is not counted
        p_oof_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            oof[g] |=> $stable(accepted[g*BYTE_W +: BYTE_W]));
        // R5: replaced value lands in history
        p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(accepted[g*BYTE_W +: BYTE_W]) |->
            history[g*BYTE_W +: BYTE_W] == $past(accepted[g*BYTE_W +: BYTE_W]));
        // R7: change sets flag
        p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(accepted[g*BYTE_W +: BYTE_W]) |-> change_flag[g]);
        // R7: flag is sticky without clear
        p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (change_flag[g] && !flag_clr[g]) |=> change_flag[g]);
        // R8: an unmasked flag raises the interrupt
        p_irq_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (change_flag[g] && !irq_mask[g]) |-> irq);
    end

    // R8: interrupt needs some unmasked flag
    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((change_flag & ~irq_mask) != '0));
endmodule

bind path_byte_monitor pbm_checker #(
    .NUM_TRIB (NUM_TRIB),
    .BYTE_W   (BYTE_W)
) u_pbm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .oof         (oof),
    .irq_mask    (irq_mask),
    .flag_clr    (flag_clr),
    .accepted    (accepted),
    .history     (history),
    .change_flag (change_flag),
    .irq         (irq)
);

// File: tb/tb_path_byte_monitor.sv
`timescale 1ns/1ps
module tb_path_byte_monitor;
    localparam int NT = 3;
    localparam int BW = 8;
    localparam int TW = 4;
    localparam int NV = 19;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NT-1:0]   frame_valid = '0;
    logic [NT*BW-1:0] frame_byte = '0;
    logic [NT-1:0]   oof = '0;
    logic [TW-1:0]   persist_thr = '0;
    logic [NT-1:0]   irq_mask = '0;
    logic [NT-1:0]   flag_clr = '0;
    logic [NT*BW-1:0] accepted;
    logic [NT*BW-1:0] history;
    logic [NT-1:0]   change_flag;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    path_byte_monitor #(.NUM_TRIB(NT), .BYTE_W(BW), .THR_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
        .frame_byte(frame_byte), .oof(oof), .persist_thr(persist_thr),
        .irq_mask(irq_mask), .flag_clr(flag_clr), .accepted(accepted),
        .history(history), .change_flag(change_flag), .irq(irq)
    );

    // Lane 0 vectors: {oof, byte, thr, expected accepted, expected history}
    localparam logic [28:0] TBL [NV] = '{
        {1'b0, 8'hA5, 4'd3, 8'h00, 8'h00},  // R2 run 1
        {1'b0, 8'hA5, 4'd3, 8'h00, 8'h00},  // R2 run 2
        {1'b0, 8'hA5, 4'd3, 8'hA5, 8'h00},  // R2 accepted at run 3
        {1'b0, 8'h3C, 4'd3, 8'hA5, 8'h00},
        {1'b0, 8'h3C, 4'd3, 8'hA5, 8'h00},
        {1'b0, 8'h77, 4'd3, 8'hA5, 8'h00},  // R3 restart
        {1'b0, 8'h3C, 4'd3, 8'hA5, 8'h00},
        {1'b0, 8'h3C, 4'd3, 8'hA5, 8'h00},
        {1'b0, 8'h3C, 4'd3, 8'h3C, 8'hA5},  // R5 history shift
        {1'b0, 8'h3C, 4'd3, 8'h3C, 8'hA5},  // R6 re-confirm
        {1'b1, 8'h5A, 4'd3, 8'h3C, 8'hA5},  // R9 ignored under oof
        {1'b0, 8'h5A, 4'd3, 8'h3C, 8'hA5},
        {1'b0, 8'h5A, 4'd3, 8'h3C, 8'hA5},
        {1'b1, 8'h5A, 4'd3, 8'h3C, 8'hA5},  // R9 run discarded
        {1'b0, 8'h5A, 4'd3, 8'h3C, 8'hA5},
        {1'b0, 8'h5A, 4'd3, 8'h3C, 8'hA5},
        {1'b0, 8'h5A, 4'd3, 8'h5A, 8'h3C},
        {1'b0, 8'h11, 4'd0, 8'h11, 8'h5A},  // R4 zero acts as one
        {1'b0, 8'h11, 4'd0, 8'h11, 8'h5A}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame(input int t, input logic [7:0] b, input logic o,
                         input logic [NT-1:0] clr);
        @(negedge clk);
        frame_valid[t] = 1'b1;
        frame_byte[t*BW +: BW] = b;
        oof[t] = o;
        flag_clr = clr;
        @(negedge clk);
        frame_valid = '0;
        oof = '0;
        flag_clr = '0;
    endtask

    task automatic clr_pulse(input logic [NT-1:0] clr);
        @(negedge clk);
        flag_clr = clr;
        @(negedge clk);
        flag_clr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 accepted", 32'(accepted), 32'h0);
        chk("R1 history", 32'(history), 32'h0);
        chk("R1 flags", 32'(change_flag), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            persist_thr = TBL[i][19:16];
            frame(0, TBL[i][27:20], TBL[i][28], '0);
            chk($sformatf("R2/R3/R4/R5/R9 vec %0d accepted", i),
                32'(accepted[7:0]), 32'(TBL[i][15:8]));
            chk($sformatf("R5 vec %0d history", i),
                32'(history[7:0]), 32'(TBL[i][7:0]));
        end

        // R7/R8 sticky flag and interrupt
        chk("R7 flag0 set", 32'(change_flag), 32'h1);
        chk("R8 irq unmasked", 32'(irq), 32'h1);
        irq_mask = 3'b001;
        @(negedge clk);
        chk("R8 irq masked", 32'(irq), 32'h0);
        irq_mask = '0;
        repeat (2) @(negedge clk);
        chk("R7 flag held", 32'(change_flag), 32'h1);
        clr_pulse(3'b001);
        chk("R7 flag cleared", 32'(change_flag), 32'h0);
        chk("R8 irq low after clear", 32'(irq), 32'h0);

        // R6 re-confirming accepted value
        persist_thr = 4'd1;
        frame(0, 8'h11, 1'b0, '0);
        chk("R6 no flag", 32'(change_flag), 32'h0);
        chk("R6 history kept", 32'(history[7:0]), 32'h5A);

        // R10 lanes independent
        persist_thr = 4'd2;
        frame(1, 8'h42, 1'b0, '0);
        frame(2, 8'h99, 1'b1, '0);
        frame(1, 8'h42, 1'b0, 3'b001);
        chk("R10 lane1 accepted", 32'(accepted[15:8]), 32'h42);
        chk("R10 lane1 history", 32'(history[15:8]), 32'h00);
        chk("R10 lane0 untouched", 32'(accepted[7:0]), 32'h11);
        chk("R10 lane2 untouched", 32'(accepted[23:16]), 32'h00);
        chk("R10 flags", 32'(change_flag), 32'h2);
        irq_mask = 3'b010;
        @(negedge clk);
        chk("R8 irq lane1 masked", 32'(irq), 32'h0);
        irq_mask = '0;

        // R11 idle cycles inside a run
        frame(2, 8'h99, 1'b0, '0);
        repeat (5) @(negedge clk);
        chk("R11 not yet", 32'(accepted[23:16]), 32'h00);
        frame(2, 8'h99, 1'b0, '0);
        chk("R11 accepted after gap", 32'(accepted[23:16]), 32'h99);

        // R7 set wins over clear in same cycle
        clr_pulse(3'b100);
        chk("R7 flag2 cleared", 32'(change_flag[2]), 32'h0);
        persist_thr = 4'd1;
        frame(2, 8'h66, 1'b0, 3'b100);
        chk("R7 set wins", 32'(change_flag[2]), 32'h1);
        chk("R5 lane2 history", 32'(history[23:16]), 32'h99);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 accepted after reset", 32'(accepted), 32'h0);
        chk("R1 flags after reset", 32'(change_flag), 32'h0);
        chk("R1 irq after reset", 32'(irq), 32'h0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule